// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry/Overflow Flags

This unit performs the shift and rotate operations of a 64-bit integer datapath on operands of 1, 2, 4 or 8 bytes. Each issued operation takes a source value, a count, the previous destination register value and the previous flag word. It produces a new destination value, in which only the low operand-size bytes are replaced, and a new flag word, in which only the carry, extra-carry and overflow bits named by a per-operation select mask may change. All other flag bits, including zero, sign and parity, pass through untouched.

There are seven operations: logical left shift, logical right shift, arithmetic right shift, rotate left, rotate right, and rotate left or right through the carry flag. Every operation has its own carry and overflow rule. A count that reduces to zero leaves the whole flag word as it was. Results are registered: an operation presented with `issue` high appears on the outputs after the next rising clock edge, and the outputs hold while `issue` is low.

Top module: `shift_rotate_unit`

## Requirements
- R1: The effective count is `cnt_val[5:0]` when `size_code` is 3 (8 bytes) and `cnt_val[4:0]` otherwise, so bit 5 of the count has no effect on 1-, 2- and 4-byte operations. `size_code` 0, 1, 2, 3 selects a width W of 8, 16, 32, 64 bits.
- R2: When the effective count is zero, `flags_new` equals `flags_old` exactly, whatever the operation and select mask.
- R3: Flag positions are carry at bit 0, overflow at bit 11 and extra-carry at bit 16. `flag_sel` uses the same positions. With a nonzero count, each of these three bits that is selected is cleared and then set to its rule's value (the extra-carry bit takes the carry value). Every unselected bit, and every bit outside the three, is copied from `flags_old`.
- R4: The result replaces bits W-1..0 of `dst_old`. Bits above W are copied from `dst_old`. Source bits above W have no effect.
- R5: Operation 0, logical left shift: vacated bits fill with 0. Carry is source bit W-c (0 when c exceeds W). Overflow is carry XOR result bit W-1.
- R6: Operation 1, logical right shift: vacated bits fill with 0. Carry is source bit c-1 (0 when c-1 is at or above W). Overflow is source bit W-1.
- R7: Operation 2, arithmetic right shift: vacated bits fill with source bit W-1. Carry is source bit c-1, where positions at or above W read as the sign bit. A selected overflow bit is cleared.
- R8: Operation 3, rotate left by c mod W: carry is result bit 0. Overflow is result bit W-1 XOR result bit 0.
- R9: Operation 4, rotate right by c mod W: carry is result bit W-1. Overflow is result bit W-1 XOR result bit W-2.
- R10: Operation 5, rotate left through carry: the (W+1)-bit ring formed by the incoming carry above the source rotates left by c mod (W+1). Carry is ring bit W-(c mod (W+1)), which is the incoming carry when that amount is 0. Overflow is result bit W-1 XOR the new carry.
- R11: Operation 6, rotate right through carry: the same ring rotates right by c mod (W+1). Carry is ring bit (c mod (W+1))-1, which is the incoming carry when that amount is 0. Overflow is the incoming carry XOR source bit W-1.
- R12: Both outputs are zero from reset until the first issued operation. An issued operation shows on the outputs after the next rising edge. With `issue` low, the outputs hold.
- R13: Operation code 7 is a no-operation: an issued code 7 leaves `dst_new` equal to `dst_old` and `flags_new` equal to `flags_old`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | Capture the operation on this clock edge |
| op_code | input | 3 | Operation select (encodings in R5 to R11, R13) |
| size_code | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| src_val | input | 64 | Source operand |
| cnt_val | input | 6 | Low bits of the count operand |
| dst_old | input | 64 | Previous destination register value |
| flags_old | input | 32 | Previous flag word |
| flag_sel | input | 32 | Flags this operation may write |
| dst_new | output | 64 | Registered new destination value |
| flags_new | output | 32 | Registered new flag word |

## Verification
Directed cases drive each operation with a zero count, a count that reaches W exactly, and counts beyond W on narrow sizes. These separate the out-of-range carry rules, sign fill and the zero-count flag freeze. Rotates through carry are tried at a count of W+1, where the ring returns to its start and the carry must come back unchanged. This tells apart a ring of W+1 bits from a plain rotate. Select masks of none, overflow only and all three show the masked clear-then-set behaviour. Seeded random operations with random sizes, counts, destinations and flag words, plus idle cycles with changing inputs, exercise merging and output holding.

// File: rtl/srot_pkg.sv
package srot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } srot_op_e;

  // fixed flag word positions
  localparam int CF_BIT = 0;
  localparam int OF_BIT = 11;
  localparam int XC_BIT = 16;

endpackage

// File: rtl/sru_count_dec.sv
module sru_count_dec #(
  parameter int DATA_W = 64,
  parameter int CW     = $clog2(DATA_W)
) (
  input  logic [1:0]        size_code,
  input  logic [CW-1:0]     cnt_raw,
  output logic [CW:0]       width,
  output logic [CW-1:0]     eff_cnt,
  output logic [CW-1:0]     rot_amt,
  output logic [CW:0]       rc_amt,
  output logic [DATA_W-1:0] size_mask
);

  localparam int RC_STEPS = 3;

  logic [CW:0] ring_len;

  assign width    = (CW+1)'(8) << size_code;
  assign ring_len = width + (CW+1)'(1);
  // only the widest size uses the top count bit
  assign eff_cnt  = (size_code == 2'd3) ? cnt_raw : {1'b0, cnt_raw[CW-2:0]};
  assign rot_amt  = eff_cnt & (width[CW-1:0] - CW'(1));

  // count mod (W+1) by bounded subtraction
  always_comb begin
    rc_amt = {1'b0, eff_cnt};
    for (int k = 0; k < RC_STEPS; k++) begin
      if (rc_amt >= ring_len) rc_amt = rc_amt - ring_len;
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      size_mask[i] = (i < int'(width));
    end
  end

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import srot_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CW     = $clog2(DATA_W)
) (
  input  srot_op_e          op,
  input  logic [DATA_W-1:0] src,
  input  logic              cf_in,
  input  logic [CW:0]       width,
  input  logic [CW-1:0]     eff_cnt,
  input  logic [CW-1:0]     rot_amt,
  input  logic [CW:0]       rc_amt,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    int wi;
    int ci;
    int ri;
    int qi;
    int p;
    logic sign;
    wi   = int'(width);
    ci   = int'(eff_cnt);
    ri   = int'(rot_amt);
    qi   = int'(rc_amt);
    p    = wi - 1;
    sign = src[p[CW-1:0]];
    res  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = 0;
      if (i < wi) begin
        case (op)
          OP_SHL: begin
            p = i - ci;
            if (p >= 0) res[i] = src[p[CW-1:0]];
          end
          OP_SHR, OP_SAR: begin
            p = i + ci;
            if (p < wi)              res[i] = src[p[CW-1:0]];
            else if (op == OP_SAR)   res[i] = sign;
          end
          OP_ROL: begin
            p = i - ri;
            if (p < 0) p = p + wi;
            res[i] = src[p[CW-1:0]];
          end
          OP_ROR: begin
            p = i + ri;
            if (p >= wi) p = p - wi;
            res[i] = src[p[CW-1:0]];
          end
          OP_RCL: begin
            p = i - qi;
            if (p < 0) p = p + wi + 1;
            res[i] = (p == wi) ? cf_in : src[p[CW-1:0]];
          end
          OP_RCR: begin
            p = i + qi;
            if (p > wi) p = p - wi - 1;
            res[i] = (p == wi) ? cf_in : src[p[CW-1:0]];
          end
          default: res[i] = src[i];
        endcase
      end
    end
  end

endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
  import srot_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int CW     = $clog2(DATA_W)
) (
  input  srot_op_e          op,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] res,
  input  logic [CW:0]       width,
  input  logic [CW-1:0]     eff_cnt,
  input  logic [CW:0]       rc_amt,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [FLAG_W-1:0] sel,
  output logic [FLAG_W-1:0] flags_out
);

  localparam logic [FLAG_W-1:0] CF_M = FLAG_W'(1) << CF_BIT;
  localparam logic [FLAG_W-1:0] OF_M = FLAG_W'(1) << OF_BIT;
  localparam logic [FLAG_W-1:0] XC_M = FLAG_W'(1) << XC_BIT;

  logic cf_in;
  logic cf_val;
  logic of_val;

  assign cf_in = flags_in[CF_BIT];

  always_comb begin
    int wi;
    int ci;
    int qi;
    int p;
    int t;
    logic src_msb;
    logic res_msb;
    logic res_smsb;
    wi       = int'(width);
    ci       = int'(eff_cnt);
    qi       = int'(rc_amt);
    t        = wi - 1;
    src_msb  = src[t[CW-1:0]];
    res_msb  = res[t[CW-1:0]];
    t        = wi - 2;
    res_smsb = res[t[CW-1:0]];
    cf_val   = 1'b0;
    of_val   = 1'b0;
    p        = 0;
    case (op)
      OP_SHL: begin
        p      = wi - ci;
        cf_val = (p >= 0 && p < wi) ? src[p[CW-1:0]] : 1'b0;
        of_val = cf_val ^ res_msb;
      end
      OP_SHR: begin
        p      = ci - 1;
        cf_val = (p >= 0 && p < wi) ? src[p[CW-1:0]] : 1'b0;
        of_val = src_msb;
      end
      OP_SAR: begin
        p = ci - 1;
        if (p < 0)       cf_val = 1'b0;
        else if (p < wi) cf_val = src[p[CW-1:0]];
        else             cf_val = src_msb;
      end
      OP_ROL: begin
        cf_val = res[0];
        of_val = res_msb ^ res[0];
      end
      OP_ROR: begin
        cf_val = res_msb;
        of_val = res_msb ^ res_smsb;
      end
      OP_RCL: begin
        p      = wi - qi;
        cf_val = (p >= wi) ? cf_in : src[p[CW-1:0]];
        of_val = res_msb ^ cf_val;
      end
      OP_RCR: begin
        p      = qi - 1;
        cf_val = (p < 0) ? cf_in : src[p[CW-1:0]];
        of_val = cf_in ^ src_msb;
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_out = flags_in;
    if (eff_cnt != '0 && op != OP_NOP) begin
      flags_out = flags_in & ~(sel & (CF_M | OF_M | XC_M));
      if (cf_val) flags_out = flags_out | (sel & (CF_M | XC_M));
      if (of_val) flags_out = flags_out | (sel & OF_M);
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int CW     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op_code,
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] src_val,
  input  logic [CW-1:0]     cnt_val,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [FLAG_W-1:0] flags_old,
  input  logic [FLAG_W-1:0] flag_sel,
  output logic [DATA_W-1:0] dst_new,
  output logic [FLAG_W-1:0] flags_new
);

  srot_op_e          op;
  logic              rst_meta;
  logic              rst_q;
  logic [CW:0]       width;
  logic [CW-1:0]     eff_cnt;
  logic [CW-1:0]     rot_amt;
  logic [CW:0]       rc_amt;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] res;
  logic [FLAG_W-1:0] flags_calc;
  logic [DATA_W-1:0] dst_nx;
  logic [FLAG_W-1:0] flags_nx;

  assign op = srot_op_e'(op_code);

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  sru_count_dec #(.DATA_W(DATA_W), .CW(CW)) u_dec (
    .size_code (size_code),
    .cnt_raw   (cnt_val),
    .width     (width),
    .eff_cnt   (eff_cnt),
    .rot_amt   (rot_amt),
    .rc_amt    (rc_amt),
    .size_mask (size_mask)
  );

  sru_datapath #(.DATA_W(DATA_W), .CW(CW)) u_dp (
    .op      (op),
    .src     (src_val),
    .cf_in   (flags_old[CF_BIT]),
    .width   (width),
    .eff_cnt (eff_cnt),
    .rot_amt (rot_amt),
    .rc_amt  (rc_amt),
    .res     (res)
  );

  sru_flag_gen #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .CW(CW)) u_flg (
    .op        (op),
    .src       (src_val),
    .res       (res),
    .width     (width),
    .eff_cnt   (eff_cnt),
    .rc_amt    (rc_amt),
    .flags_in  (flags_old),
    .sel       (flag_sel),
    .flags_out (flags_calc)
  );

  always_comb begin
    dst_nx   = dst_new;
    flags_nx = flags_new;
    if (issue) begin
      flags_nx = flags_calc;
      if (op == OP_NOP) dst_nx = dst_old;
      else              dst_nx = (dst_old & ~size_mask) | (res & size_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dst_new   <= '0;
      flags_new <= '0;
    end else begin
      dst_new   <= dst_nx;
      flags_new <= flags_nx;
    end
  end

  assert_zero_count_freeze_R2: assert property (@(posedge clk) disable iff (!rst_q)
    issue && eff_cnt == '0 |=> flags_new == $past(flags_old));

  assert_unselected_pass_R3: assert property (@(posedge clk) disable iff (!rst_q)
    issue |=> ((flags_new ^ $past(flags_old)) & ~$past(flag_sel)) == '0);

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_q)
    issue |=> ((dst_new ^ $past(dst_old)) & ~$past(size_mask)) == '0);

  assert_sar_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_q)
    issue && op == OP_SAR && eff_cnt != '0 && flag_sel[OF_BIT] |=> !flags_new[OF_BIT]);

  assert_rol_carry_lsb_R8: assert property (@(posedge clk) disable iff (!rst_q)
    issue && op == OP_ROL && eff_cnt != '0 && flag_sel[CF_BIT] |=> flags_new[CF_BIT] == dst_new[0]);

  assert_nop_keeps_dst_R13: assert property (@(posedge clk) disable iff (!rst_q)
    issue && op == OP_NOP |=> dst_new == $past(dst_old));

endmodule

// File: tb/shift_rotate_unit_bench.sv
`timescale 1ns/1ps
module shift_rotate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [2:0]  op_code;
  logic [1:0]  size_code;
  logic [63:0] src_val;
  logic [5:0]  cnt_val;
  logic [63:0] dst_old;
  logic [31:0] flags_old;
  logic [31:0] flag_sel;
  logic [63:0] dst_new;
  logic [31:0] flags_new;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .size_code(size_code), .src_val(src_val), .cnt_val(cnt_val),
    .dst_old(dst_old), .flags_old(flags_old), .flag_sel(flag_sel),
    .dst_new(dst_new), .flags_new(flags_new)
  );

  function automatic logic bitof(logic [63:0] v, int p);
    if (p < 0 || p > 63) return 1'b0;
    return v[p[5:0]];
  endfunction

  function automatic logic [63:0] wmask(int w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
      input logic [63:0] src, input logic [5:0] cnt, input logic [63:0] dst,
      input logic [31:0] flg, input logic [31:0] sel,
      output logic [63:0] ed, output logic [31:0] ef);
    int w, c, k;
    logic [63:0] m, s, sx, r;
    logic [129:0] ring, rot, rmask, tmp;
    logic cfv, ofv, cin;
    w = 8 << sz;
    c = (sz == 2'd3) ? int'(cnt) : int'(cnt[4:0]);
    m = wmask(w);
    s = src & m;
    cin = flg[0];
    sx = bitof(s, w - 1) ? (s | ~m) : s;
    r = '0; cfv = 1'b0; ofv = 1'b0; k = 0;
    ring  = {66'd0, s} | ({129'd0, cin} << w);
    rmask = ({129'd0, 1'b1} << (w + 1)) - 130'd1;
    case (op)
      3'd0: begin r = (s << c) & m; cfv = bitof(s, w - c); ofv = cfv ^ bitof(r, w - 1); end
      3'd1: begin r = s >> c; cfv = bitof(s, c - 1); ofv = bitof(s, w - 1); end
      3'd2: begin r = 64'($signed(sx) >>> c) & m; cfv = bitof(sx, c - 1); ofv = 1'b0; end
      3'd3: begin k = c % w; r = ((s << k) | (s >> (w - k))) & m;
                  cfv = r[0]; ofv = bitof(r, w - 1) ^ r[0]; end
      3'd4: begin k = c % w; r = ((s >> k) | (s << (w - k))) & m;
                  cfv = bitof(r, w - 1); ofv = cfv ^ bitof(r, w - 2); end
      3'd5: begin k = c % (w + 1); rot = ((ring << k) | (ring >> (w + 1 - k))) & rmask;
                  r = rot[63:0] & m; tmp = rot >> w; cfv = tmp[0]; ofv = bitof(r, w - 1) ^ cfv; end
      3'd6: begin k = c % (w + 1); rot = ((ring >> k) | (ring << (w + 1 - k))) & rmask;
                  r = rot[63:0] & m; tmp = rot >> w; cfv = tmp[0]; ofv = cin ^ bitof(s, w - 1); end
      default: ;
    endcase
    if (op == 3'd7) begin
      ed = dst; ef = flg;
      return;
    end
    ed = (dst & ~m) | (r & m);
    if (c == 0) ef = flg;
    else begin
      ef = flg & ~(sel & 32'h0001_0801);
      if (cfv) ef = ef | (sel & 32'h0001_0001);
      if (ofv) ef = ef | (sel & 32'h0000_0800);
    end
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      3'd6: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run_op(logic [2:0] op, logic [1:0] sz, logic [63:0] src,
      logic [5:0] cnt, logic [63:0] dst, logic [31:0] flg, logic [31:0] sel, string tag);
    logic [63:0] ed;
    logic [31:0] ef;
    string t;
    @(negedge clk);
    op_code = op; size_code = sz; src_val = src; cnt_val = cnt;
    dst_old = dst; flags_old = flg; flag_sel = sel; issue = 1'b1;
    model(op, sz, src, cnt, dst, flg, sel, ed, ef);
    @(negedge clk);
    issue = 1'b0;
    t = (tag == "") ? op_tag(op) : tag;
    chk(t, "dst", dst_new, ed);
    chk(t, "flags", {32'd0, flags_new}, {32'd0, ef});
  endtask

  task automatic idle_hold;
    logic [63:0] d;
    logic [31:0] f;
    d = dst_new; f = flags_new;
    @(negedge clk);
    src_val = {$urandom, $urandom}; dst_old = {$urandom, $urandom};
    flags_old = $urandom; flag_sel = '1; cnt_val = 6'd5; issue = 1'b0;
    @(negedge clk);
    chk("R12", "hold dst", dst_new, d);
    chk("R12", "hold flags", {32'd0, flags_new}, {32'd0, f});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [2:0]  rop;
    logic [1:0]  rsz;
    logic [5:0]  rc;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 1'b0; issue = 1'b0; op_code = '0; size_code = '0; src_val = '0;
    cnt_val = '0; dst_old = '0; flags_old = '0; flag_sel = '0;
    repeat (3) @(negedge clk);
    chk("R12", "reset dst", dst_new, 64'd0);
    chk("R12", "reset flags", {32'd0, flags_new}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "post-reset dst", dst_new, 64'd0);

    // R5 .. R11 directed, all three flags selected
    run_op(3'd0, 2'd0, 64'h81, 6'd1, 64'hFFFF_FFFF_FFFF_FF00, 32'h0, 32'h0001_0801, "R5");
    run_op(3'd0, 2'd0, 64'h01, 6'd8, 64'h0, 32'h0, 32'h0001_0801, "R5");
    run_op(3'd0, 2'd1, 64'hFFFF, 6'd20, 64'h0, 32'hFFFF_FFFF, 32'h0001_0801, "R5");
    run_op(3'd1, 2'd2, 64'h8000_0001, 6'd1, 64'hAAAA_AAAA_0000_0000, 32'h0, 32'h0001_0801, "R6");
    run_op(3'd1, 2'd0, 64'hFF, 6'd9, 64'h0, 32'h0, 32'h0001_0801, "R6");
    run_op(3'd2, 2'd0, 64'h80, 6'd12, 64'h0, 32'h0000_0800, 32'h0001_0801, "R7");
    run_op(3'd2, 2'd3, 64'h8000_0000_0000_0010, 6'd5, 64'h0, 32'h0, 32'h0001_0801, "R7");
    run_op(3'd3, 2'd0, 64'h81, 6'd1, 64'h0, 32'h0, 32'h0001_0801, "R8");
    run_op(3'd3, 2'd3, 64'h8000_0000_0000_0000, 6'd63, 64'h0, 32'h0, 32'h0001_0801, "R8");
    run_op(3'd4, 2'd0, 64'h01, 6'd1, 64'h0, 32'h0, 32'h0001_0801, "R9");
    run_op(3'd4, 2'd1, 64'h0003, 6'd17, 64'h0, 32'h0, 32'h0001_0801, "R9");
    run_op(3'd5, 2'd0, 64'h80, 6'd1, 64'h0, 32'h0, 32'h0001_0801, "R10");
    run_op(3'd5, 2'd0, 64'h5A, 6'd9, 64'h0, 32'h1, 32'h0001_0801, "R10");
    run_op(3'd6, 2'd0, 64'h01, 6'd1, 64'h0, 32'h1, 32'h0001_0801, "R11");
    run_op(3'd6, 2'd0, 64'hA5, 6'd9, 64'h0, 32'h1, 32'h0001_0801, "R11");
    run_op(3'd6, 2'd3, 64'h1, 6'd63, 64'h0, 32'h0, 32'h0001_0801, "R11");
    // R1 count masking
    run_op(3'd0, 2'd0, 64'h0F, 6'h23, 64'h0, 32'h0, 32'h0001_0801, "R1");
    run_op(3'd1, 2'd3, 64'hF000_0000_0000_0000, 6'h23, 64'h0, 32'h0, 32'h0001_0801, "R1");
    run_op(3'd1, 2'd1, 64'h1234, 6'h20, 64'h0, 32'h0000_0801, 32'h0001_0801, "R1");
    // R2 zero count, every operation
    for (int o = 0; o < 7; o++)
      run_op(3'(o), 2'(o % 4), {$urandom, $urandom}, 6'd0, {$urandom, $urandom},
             $urandom, 32'h0001_0801, "R2");
    // R3 select masks
    run_op(3'd0, 2'd0, 64'hC0, 6'd1, 64'h0, 32'hFFFE_F7FE, 32'h0, "R3");
    run_op(3'd0, 2'd0, 64'h40, 6'd1, 64'h0, 32'h0001_0001, 32'h0000_0800, "R3");
    run_op(3'd1, 2'd0, 64'h03, 6'd1, 64'h0, 32'h0000_0800, 32'h0000_0001, "R3");
    // R4 merge
    run_op(3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 6'd4, 64'h1122_3344_5566_7788, 32'h0, 32'h0, "R4");
    run_op(3'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 6'd1, 64'hDEAD_BEEF_0000_0000, 32'h0, 32'h0, "R4");
    // R13 no-op
    run_op(3'd7, 2'd3, 64'h1, 6'd3, 64'hCAFE_F00D_1234_5678, 32'h0000_0801, 32'hFFFF_FFFF, "R13");
    idle_hold();

    for (int n = 0; n < 600; n++) begin
      rop = 3'($urandom_range(0, 7));
      rsz = 2'($urandom_range(0, 3));
      if (($urandom % 4) == 0) rc = 6'($urandom);
      else rc = 6'($urandom_range(0, (8 << rsz) + 2 > 63 ? 63 : (8 << rsz) + 2));
      run_op(rop, rsz, {$urandom, $urandom}, rc, {$urandom, $urandom},
             $urandom, $urandom, "");
      if ((n % 50) == 49) idle_hold();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule